// File: doc/BRIEF.md
# CDR Control and Rate-Window Logic

This block holds the digital control state of a clock-and-data-recovery front end. A host reaches it through a plain single-cycle register port: a write strobe with address and data, and a read data bus that always reflects the addressed register. From the stored settings it forms the outputs that the rest of the receiver consumes. These are a 9-bit coarse rate word, a loss-of-signal indication with selectable sense, a one-cycle pulse that restarts frequency acquisition, a lock-permitted flag, and an enable for a divide-by-two output clock stage.

In limited-range mode a measured 9-bit rate code, which arrives on a plain input, is compared against programmable lower and upper limits. Each limit is split across its own 8-bit register for bits [8:1] and one bit of a shared LSB register. Acquisition is restarted by writing the trigger bit high and later writing it low. The pulse comes from that falling write, and no other setting changes.

The register map is as follows. 0x0 holds the rate byte. 0x1 is an auxiliary register whose bit 0 is used. 0x2 is the acquisition control register, with the trigger at bit 5. 0x3 is signal control, with loss-of-signal polarity at bit 2. 0x4 holds the low limit bits [8:1] and 0x5 the high limit bits [8:1]. 0x6 is the limit LSB register: bit 0 goes to the low limit and bit 1 to the high limit. 0x7 is mode select, with the limited-range enable at bit 3. 0x8 is clock control. Addresses 0x9 to 0xF are not mapped.

Top module: `cdr_ctl_top`

## Requirements
- R1: After reset every register reads 0x00, acq_start is 0, lock_ok is 1, clk_div2_en is 0, and los_out equals los_raw.
- R2: A write to a mapped address (0x0 to 0x8) stores the full byte, and rd_data returns it in the same cycle as the address. A write to 0x9 to 0xF changes no register, and a read from those addresses returns 0x00.
- R3: coarse_rate equals {register 0x0, bit 0 of register 0x1}. coarse_valid is high exactly when lol is low.
- R4: With bit 2 of register 0x3 clear, los_out equals los_raw (active high). With it set, los_out is the inverse of los_raw (active low).
- R5: acq_start pulses high for exactly one cycle, in the cycle after a write to 0x2 that clears bit 5 while the stored bit 5 is 1. A write that leaves bit 5 at 0 from 0, or sets it to 1, gives no pulse.
- R6: A write to 0x2 that fires acq_start leaves every other register and the mode settings unchanged.
- R7: The low limit is {register 0x4, bit 0 of 0x6} and the high limit is {register 0x5, bit 1 of 0x6}. In limited-range mode lock_ok is 1 exactly when low ≤ meas_code ≤ high, both bounds inclusive; an inverted window never permits lock.
- R8: Limited-range mode is on while bit 3 of register 0x7 is set. While it is clear, lock_ok is 1 whatever the limits and the code.
- R9: clk_div2_en is 1 exactly when register 0x8 holds 0x02; any other value clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register, zero if unmapped |
| lol | input | 1 | Loss-of-lock indication from the PLL |
| los_raw | input | 1 | Raw loss-of-signal detector, high on loss |
| meas_code | input | 9 | Measured rate code |
| coarse_rate | output | 9 | Coarse rate readback word |
| coarse_valid | output | 1 | Coarse word is meaningful (lock held) |
| los_out | output | 1 | Loss-of-signal with programmed sense |
| acq_start | output | 1 | One-cycle acquisition restart pulse |
| lock_ok | output | 1 | Measured rate lies in permitted window |
| clk_div2_en | output | 1 | Route output clock through divide-by-two |

## Verification
The assertions check on every cycle that the acquisition pulse lasts one cycle and follows a stored one being cleared. They also check that such a write disturbs no other setting, that a disabled window always permits lock, that codes outside the limits are refused, and that the loss-of-signal and coarse-valid outputs track their inputs. Only the bench's scenarios can show that the limits are split correctly between the byte and LSB registers and that both bounds are inclusive. The same holds for byte-exact readback, for writes to unmapped addresses leaving the map untouched, and for the exact 0x02 decode of the clock control register.

// File: rtl/cdr_ctl_pkg.sv
package cdr_ctl_pkg;
  localparam int REG_COUNT = 9;
  localparam int CODE_W    = 9;
  localparam int BYTE_W    = 8;

  localparam int A_RATE = 0;
  localparam int A_AUX  = 1;
  localparam int A_ACQ  = 2;
  localparam int A_SIG  = 3;
  localparam int A_LO8  = 4;
  localparam int A_HI8  = 5;
  localparam int A_LSB  = 6;
  localparam int A_MODE = 7;
  localparam int A_CLK  = 8;

  localparam int B_ACQ     = 5;
  localparam int B_LOS_POL = 2;
  localparam int B_WIN_EN  = 3;
  localparam int B_LSB_LO  = 0;
  localparam int B_LSB_HI  = 1;

  localparam logic [BYTE_W-1:0] CLK_DIV2_CODE = 8'h02;

  typedef struct packed {
    logic [BYTE_W-1:0] rate;
    logic              aux0;
    logic              los_pol;
    logic [CODE_W-1:0] lo;
    logic [CODE_W-1:0] hi;
    logic              win_en;
    logic              div2;
  } cdr_cfg_t;
endpackage

// File: rtl/cdr_ctl_regs.sv
module cdr_ctl_regs
  import cdr_ctl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output cdr_cfg_t          cfg,
  output logic              acq_start
);
  localparam int NREG = REG_COUNT;

  logic [BYTE_W-1:0] regs_q [NREG];
  logic [BYTE_W-1:0] regs_d [NREG];
  logic              acq_q, acq_d;
  logic              hit;

  assign hit = (int'(addr) < NREG);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      regs_d[i] = regs_q[i];
    end
    if (wr_en && hit) begin
      regs_d[addr] = wr_data;
    end
    acq_d = wr_en && (int'(addr) == A_ACQ) && !wr_data[B_ACQ] && regs_q[A_ACQ][B_ACQ];
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[g] <= '0;
        end else if (wr_en && hit && (int'(addr) == g)) begin
          regs_q[g] <= regs_d[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acq_q <= 1'b0;
    else        acq_q <= acq_d;
  end

  always_comb begin
    rd_data = hit ? regs_q[addr] : '0;
  end

  always_comb begin
    cfg.rate    = regs_q[A_RATE];
    cfg.aux0    = regs_q[A_AUX][0];
    cfg.los_pol = regs_q[A_SIG][B_LOS_POL];
    cfg.lo      = {regs_q[A_LO8], regs_q[A_LSB][B_LSB_LO]};
    cfg.hi      = {regs_q[A_HI8], regs_q[A_LSB][B_LSB_HI]};
    cfg.win_en  = regs_q[A_MODE][B_WIN_EN];
    cfg.div2    = (regs_q[A_CLK] == CLK_DIV2_CODE);
  end

  assign acq_start = acq_q;

  p_acq_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> !acq_start);

  p_acq_after_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |-> ($past(regs_q[A_ACQ][B_ACQ]) && !regs_q[A_ACQ][B_ACQ]));

  p_acq_keeps_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |-> ($stable(cfg.lo) && $stable(cfg.hi) && $stable(cfg.win_en)
                   && $stable(cfg.los_pol) && $stable(cfg.rate) && $stable(cfg.div2)));

  p_unmapped_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(cfg));
endmodule

// File: rtl/cdr_rate_window.sv
module cdr_rate_window #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_en,
  input  logic [CW-1:0] lo_lim,
  input  logic [CW-1:0] hi_lim,
  input  logic [CW-1:0] code,
  output logic          lock_ok
);
  logic above_lo, below_hi;

  always_comb begin
    above_lo = (code >= lo_lim);
    below_hi = (code <= hi_lim);
    lock_ok  = !win_en || (above_lo && below_hi);
  end

  p_off_passes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> lock_ok);

  p_under_low_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && (code < lo_lim)) |-> !lock_ok);

  p_over_high_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en && (code > hi_lim)) |-> !lock_ok);
endmodule

// File: rtl/cdr_out_stage.sv
module cdr_out_stage
  import cdr_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cdr_cfg_t          cfg,
  input  logic              lol,
  input  logic              los_raw,
  output logic [CODE_W-1:0] coarse_rate,
  output logic              coarse_valid,
  output logic              los_out,
  output logic              clk_div2_en
);
  always_comb begin
    coarse_rate  = {cfg.rate, cfg.aux0};
    coarse_valid = !lol;
    los_out      = cfg.los_pol ? !los_raw : los_raw;
    clk_div2_en  = cfg.div2;
  end

  p_los_high_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.los_pol |-> (los_out == los_raw));

  p_los_low_sense_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.los_pol |-> (los_out != los_raw));

  p_coarse_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lol |-> !coarse_valid);
endmodule

// File: rtl/cdr_ctl_top.sv
module cdr_ctl_top
  import cdr_ctl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              lol,
  input  logic              los_raw,
  input  logic [CODE_W-1:0] meas_code,
  output logic [CODE_W-1:0] coarse_rate,
  output logic              coarse_valid,
  output logic              los_out,
  output logic              acq_start,
  output logic              lock_ok,
  output logic              clk_div2_en
);
  logic     rst_meta, rst_sync;
  cdr_cfg_t cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cdr_ctl_regs #(.AW(AW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cfg       (cfg),
    .acq_start (acq_start)
  );

  cdr_rate_window #(.CW(CODE_W)) i_window (
    .clk     (clk),
    .rst_n   (rst_sync),
    .win_en  (cfg.win_en),
    .lo_lim  (cfg.lo),
    .hi_lim  (cfg.hi),
    .code    (meas_code),
    .lock_ok (lock_ok)
  );

  cdr_out_stage i_out (
    .clk          (clk),
    .rst_n        (rst_sync),
    .cfg          (cfg),
    .lol          (lol),
    .los_raw      (los_raw),
    .coarse_rate  (coarse_rate),
    .coarse_valid (coarse_valid),
    .los_out      (los_out),
    .clk_div2_en  (clk_div2_en)
  );
endmodule

// File: tb/test_cdr_ctl_top.sv
module test_cdr_ctl_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       lol, los_raw;
  logic [8:0] meas_code;
  logic [8:0] coarse_rate;
  logic       coarse_valid, los_out, acq_start, lock_ok, clk_div2_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cdr_ctl_top i_cdr_ctl_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .lol(lol), .los_raw(los_raw), .meas_code(meas_code),
    .coarse_rate(coarse_rate), .coarse_valid(coarse_valid), .los_out(los_out),
    .acq_start(acq_start), .lock_ok(lock_ok), .clk_div2_en(clk_div2_en)
  );

  // {mode[28], lo[27:19], hi[18:10], code[9:1], expect[0]}
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 9'd100, 9'd50,  9'd7,   1'b1},
    {1'b1, 9'd236, 9'd258, 9'd236, 1'b1},
    {1'b1, 9'd236, 9'd258, 9'd258, 1'b1},
    {1'b1, 9'd236, 9'd258, 9'd235, 1'b0},
    {1'b1, 9'd236, 9'd258, 9'd259, 1'b0},
    {1'b1, 9'd1,   9'd3,   9'd3,   1'b1},
    {1'b1, 9'd1,   9'd3,   9'd0,   1'b0},
    {1'b1, 9'd300, 9'd200, 9'd250, 1'b0},
    {1'b1, 9'd511, 9'd511, 9'd511, 1'b1},
    {1'b1, 9'd0,   9'd0,   9'd1,   1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [3:0] a, logic [7:0] exp);
    addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    lol = 1'b1; los_raw = 1'b1; meas_code = 9'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 9; a++) rd_check("R1 reset reg", 4'(a), 8'h00);
    check("R1 acq_start", acq_start, 0);
    check("R1 lock_ok", lock_ok, 1);
    check("R1 clk_div2_en", clk_div2_en, 0);
    check("R1 los_out", los_out, 1);

    // R7/R8 vector table
    for (int i = 0; i < NV; i++) begin
      logic [8:0] lo, hi;
      lo = VEC[i][27:19];
      hi = VEC[i][18:10];
      wr(4'h4, lo[8:1]);
      wr(4'h5, hi[8:1]);
      wr(4'h6, {6'b0, hi[0], lo[0]});
      wr(4'h7, {4'b0, VEC[i][28], 3'b0});
      meas_code = VEC[i][9:1];
      #1;
      check(VEC[i][28] ? "R7 window" : "R8 disabled", lock_ok, VEC[i][0]);
    end

    // R8: mode cleared with an excluding window
    wr(4'h4, 8'hF0); wr(4'h5, 8'h01); meas_code = 9'd400;
    wr(4'h7, 8'hF7);
    check("R8 other mode bits", lock_ok, 1);
    wr(4'h7, 8'h08);
    check("R8 enabled excludes", lock_ok, 0);

    // R2 readback and unmapped
    wr(4'h0, 8'hA5); wr(4'h1, 8'h3C); wr(4'h8, 8'h77);
    rd_check("R2 rate", 4'h0, 8'hA5);
    rd_check("R2 aux", 4'h1, 8'h3C);
    rd_check("R2 clk", 4'h8, 8'h77);
    wr(4'h9, 8'hFF); wr(4'hF, 8'h55);
    rd_check("R2 unmapped read 9", 4'h9, 8'h00);
    rd_check("R2 unmapped read F", 4'hF, 8'h00);
    rd_check("R2 rate kept", 4'h0, 8'hA5);
    rd_check("R2 clk kept", 4'h8, 8'h77);
    rd_check("R2 mode kept", 4'h7, 8'h08);

    // R3 coarse word
    wr(4'h1, 8'h01);
    check("R3 coarse lsb1", coarse_rate, 9'h14B);
    wr(4'h1, 8'hFE);
    check("R3 coarse lsb0", coarse_rate, 9'h14A);
    lol = 1'b1; #1;
    check("R3 valid lol high", coarse_valid, 0);
    lol = 1'b0; #1;
    check("R3 valid lol low", coarse_valid, 1);

    // R4 LOS polarity
    los_raw = 1'b0; #1;
    check("R4 high sense idle", los_out, 0);
    wr(4'h3, 8'h04);
    check("R4 low sense idle", los_out, 1);
    los_raw = 1'b1; #1;
    check("R4 low sense loss", los_out, 0);
    wr(4'h3, 8'hFB);
    check("R4 high sense loss", los_out, 1);

    // R5/R6 acquisition restart
    wr(4'h2, 8'h20);
    check("R5 rising no pulse", acq_start, 0);
    wr(4'h2, 8'h00);
    check("R5 pulse", acq_start, 1);
    rd_check("R6 mode kept", 4'h7, 8'h08);
    rd_check("R6 lo kept", 4'h4, 8'hF0);
    rd_check("R6 sig kept", 4'h3, 8'hFB);
    @(negedge clk);
    check("R5 pulse one cycle", acq_start, 0);
    wr(4'h2, 8'h00);
    check("R5 zero to zero", acq_start, 0);
    wr(4'h2, 8'h20);
    wr(4'h2, 8'hDF);
    check("R5 pulse other bits set", acq_start, 1);
    wr(4'h3, 8'h20);
    check("R5 other address", acq_start, 0);

    // R9 divider decode
    wr(4'h8, 8'h02);
    check("R9 div2 on", clk_div2_en, 1);
    wr(4'h8, 8'h03);
    check("R9 div2 0x03", clk_div2_en, 0);
    wr(4'h8, 8'h82);
    check("R9 div2 0x82", clk_div2_en, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule